// File: doc/BRIEF.md
# Calendar Time Counter with Selectable BCD or Binary Display

This block keeps wall-clock time in seven fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A 32 kHz enable divides down to a once-per-second boundary. At each boundary the internal binary counter moves forward by one second. This happens only when the oscillator-control field is in its running setting. Month lengths follow the calendar, and February follows the full Gregorian leap rule applied to `BaseYear` plus the two-digit year.

The surrounding interface block owns the register file and the interrupts. It sees a set of visible bytes. These bytes are refreshed from the counter at the end of a short update window, while the update-in-progress flag is high. They are shown in packed BCD or plain binary, and the hour is shown in 24-hour or 12-hour form, as selected by mode inputs. The interface block writes the visible bytes. In normal running a write reloads the counter from the visible bytes. While set mode is active the counter keeps running unseen, and on leaving set mode it is loaded from the bytes that software wrote.

Top module: `calendar_time_counter`

## Requirements
- R1: During and after reset the visible bytes are seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, day of month 0x01, month 0x01 and year 0x00, with `uip` and `updateEnded` low.
- R2: Seconds and minutes roll from 59 to 0 and carry; hours roll from 23 to 0 and carry into the day. Day of week runs 1 to 7 and then returns to 1.
- R3: The day of month returns to 1 after 31 days for months 1, 3, 5, 7, 8, 10 and 12, and after 30 days for months 4, 6, 9 and 11. Month then advances, and after month 12 it returns to 1 and the year advances. The year runs 0 to 99 and then returns to 0.
- R4: February has 29 days when the full year (`BaseYear` + year, `BaseYear` = 2000 by default) is divisible by 4 and is either not divisible by 100 or divisible by 400; otherwise it has 28 days.
- R5: With `binMode` = 0 every field is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. With `binMode` = 1 every field is the plain binary value. The same encoding is used to decode loaded bytes.
- R6: With `mode24` = 1 the hour byte shows 0 to 23. With `mode24` = 0 it shows the hour modulo 12, with bit 7 set for hours 12 to 23. When an hour byte is loaded in that mode, bit 7 adds 12 to the hour.
- R7: The second boundary advances time and starts an update window only when `oscSel` = 3'b010. With any other value, the boundary passes with no advance, no `uip` and no `updateEnded`.
- R8: `uip` rises on the clock after a second boundary and stays high for `UipTicks` enabled 32 kHz ticks. On the clock where it falls, the visible bytes take the advanced time and `updateEnded` is high for exactly one cycle.
- R9: While `setMode` = 1, `uip` is held low and the visible bytes change only by writes. `updateEnded` still pulses once per second. When `setMode` returns to 0, the counter is reloaded from the visible bytes, and the time the counter ran on during set mode is discarded.
- R10: A write with `setMode` = 0 stores `wrData` into the byte picked by `wrSel` (0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year). The counter is reloaded from all visible bytes on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick32k | input | 1 | One-cycle enable at the 32 kHz rate |
| oscSel | input | 3 | Oscillator-control field; 3'b010 runs time |
| setMode | input | 1 | Freezes the visible bytes and arms a reload |
| binMode | input | 1 | 1 = binary fields, 0 = packed BCD |
| mode24 | input | 1 | 1 = 24-hour display, 0 = 12-hour with PM in bit 7 |
| wrEn | input | 1 | Write strobe for a visible byte |
| wrSel | input | 3 | Field picked by a write |
| wrData | input | 8 | Byte written |
| secOut | output | 8 | Visible seconds |
| minOut | output | 8 | Visible minutes |
| hourOut | output | 8 | Visible hours |
| dowOut | output | 8 | Visible day of week |
| domOut | output | 8 | Visible day of month |
| monOut | output | 8 | Visible month |
| yearOut | output | 8 | Visible two-digit year |
| uip | output | 1 | Update in progress |
| updateEnded | output | 1 | One-cycle pulse at the end of each update window |

## Verification
A wrong carry or a wrong month length inside the counter stays hidden until the next update window closes. At that point every visible byte is compared with a behavioural calendar model, so the error shows within one second of simulated time. Timing faults in the control path, such as a window of the wrong length, a skipped oscillator gate or a missed reload, change the `uip` and `updateEnded` waveform, or the first byte copied after a write. The per-clock comparison catches these on the very cycle they occur.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  localparam int NumFields = 7;

  typedef struct packed {
    logic advance;
    logic copyOut;
    logic loadIn;
  } ctc_strobes_t;

  function automatic logic [7:0] toDisp(input logic [7:0] v, input logic bin);
    logic [7:0] tens;
    logic [7:0] units;
    tens  = v / 8'd10;
    units = v % 8'd10;
    return bin ? v : {tens[3:0], units[3:0]};
  endfunction

  function automatic logic [7:0] fromDisp(input logic [7:0] v, input logic bin);
    logic [7:0] hi;
    hi = {4'b0000, v[7:4]};
    return bin ? v : (hi * 8'd10 + {4'b0000, v[3:0]});
  endfunction

  function automatic logic [7:0] daysInMonth(input logic [7:0] mon, input int fullYear);
    logic leap;
    leap = (fullYear % 4 == 0) && ((fullYear % 100 != 0) || (fullYear % 400 == 0));
    case (mon)
      8'd2:                     return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/ctc_control.sv
module ctc_control
  import ctc_pkg::*;
#(
  parameter int TicksPerSecond = 32768,
  parameter int UipTicks       = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick32k,
  input  logic [2:0]   oscSel,
  input  logic         setMode,
  input  logic         wrEn,
  output ctc_strobes_t strb,
  output logic         uip,
  output logic         updateEnded
);
  localparam int PrescW = (TicksPerSecond > 1) ? $clog2(TicksPerSecond) : 1;
  localparam int WinW   = $clog2(UipTicks) + 1;

  typedef enum logic {Idle, Busy} ctc_state_t;

  ctc_state_t      state;
  logic [PrescW-1:0] presc;
  logic [WinW-1:0]   win;
  logic            setQ;
  logic            loadReq;
  logic            secEdge;
  logic            winDone;
  logic            oscRun;

  assign oscRun  = (oscSel == 3'b010);
  assign secEdge = tick32k && (presc == PrescW'(TicksPerSecond - 1));
  assign winDone = (state == Busy) && tick32k && (win == WinW'(UipTicks - 1));

  always_comb begin
    strb.advance = secEdge && (state == Idle) && oscRun;
    strb.copyOut = winDone && !setMode;
    strb.loadIn  = loadReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc       <= '0;
      state       <= Idle;
      win         <= '0;
      uip         <= 1'b0;
      updateEnded <= 1'b0;
      setQ        <= 1'b0;
      loadReq     <= 1'b0;
    end else begin
      if (tick32k) presc <= secEdge ? '0 : presc + 1'b1;

      if (strb.advance) begin
        state <= Busy;
        win   <= '0;
      end else if (state == Busy && tick32k) begin
        if (winDone) state <= Idle;
        else         win   <= win + 1'b1;
      end

      if (setMode)           uip <= 1'b0;
      else if (strb.advance) uip <= 1'b1;
      else if (winDone)      uip <= 1'b0;

      updateEnded <= winDone;
      loadReq     <= !setMode && (wrEn || setQ);
      setQ        <= setMode;
    end
  end
endmodule

// File: rtl/ctc_datapath.sv
module ctc_datapath
  import ctc_pkg::*;
#(
  parameter int BaseYear = 2000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctc_strobes_t              strb,
  input  logic                      binMode,
  input  logic                      mode24,
  input  logic                      wrEn,
  input  logic [2:0]                wrSel,
  input  logic [7:0]                wrData,
  output logic [NumFields-1:0][7:0] vis
);
  logic [7:0] secQ, minQ, hrQ, dowQ, domQ, monQ, yrQ;
  logic [7:0] nSec, nMin, nHr, nDow, nDom, nMon, nYr;
  logic [7:0] dim;
  logic [7:0] ldHr;
  logic [NumFields-1:0][7:0] fmt;

  assign dim = daysInMonth(monQ, BaseYear + int'(yrQ));

  always_comb begin
    nSec = secQ; nMin = minQ; nHr = hrQ; nDow = dowQ;
    nDom = domQ; nMon = monQ; nYr = yrQ;
    if (secQ >= 8'd59) begin
      nSec = 8'd0;
      if (minQ >= 8'd59) begin
        nMin = 8'd0;
        if (hrQ >= 8'd23) begin
          nHr  = 8'd0;
          nDow = (dowQ >= 8'd7) ? 8'd1 : dowQ + 8'd1;
          if (domQ >= dim) begin
            nDom = 8'd1;
            if (monQ >= 8'd12) begin
              nMon = 8'd1;
              nYr  = (yrQ >= 8'd99) ? 8'd0 : yrQ + 8'd1;
            end else begin
              nMon = monQ + 8'd1;
            end
          end else begin
            nDom = domQ + 8'd1;
          end
        end else begin
          nHr = hrQ + 8'd1;
        end
      end else begin
        nMin = minQ + 8'd1;
      end
    end else begin
      nSec = secQ + 8'd1;
    end
  end

  always_comb begin
    fmt[0] = toDisp(secQ, binMode);
    fmt[1] = toDisp(minQ, binMode);
    if (mode24) fmt[2] = toDisp(hrQ, binMode);
    else        fmt[2] = toDisp((hrQ >= 8'd12) ? hrQ - 8'd12 : hrQ, binMode)
                         | ((hrQ >= 8'd12) ? 8'h80 : 8'h00);
    fmt[3] = toDisp(dowQ, binMode);
    fmt[4] = toDisp(domQ, binMode);
    fmt[5] = toDisp(monQ, binMode);
    fmt[6] = toDisp(yrQ, binMode);
  end

  always_comb begin
    ldHr = fromDisp({1'b0, vis[2][6:0]}, binMode);
    if (!mode24 && vis[2][7]) ldHr = ldHr + 8'd12;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= 8'd0; minQ <= 8'd0; hrQ <= 8'd0; dowQ <= 8'd1;
      domQ <= 8'd1; monQ <= 8'd1; yrQ <= 8'd0;
    end else if (strb.loadIn) begin
      secQ <= fromDisp(vis[0], binMode);
      minQ <= fromDisp(vis[1], binMode);
      hrQ  <= ldHr;
      dowQ <= fromDisp(vis[3], binMode);
      domQ <= fromDisp(vis[4], binMode);
      monQ <= fromDisp(vis[5], binMode);
      yrQ  <= fromDisp(vis[6], binMode);
    end else if (strb.advance) begin
      secQ <= nSec; minQ <= nMin; hrQ <= nHr; dowQ <= nDow;
      domQ <= nDom; monQ <= nMon; yrQ <= nYr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vis <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    end else begin
      for (int i = 0; i < NumFields; i++) begin
        if (wrEn && int'(wrSel) == i) vis[i] <= wrData;
        else if (strb.copyOut)        vis[i] <= fmt[i];
      end
    end
  end
endmodule

// File: rtl/calendar_time_counter.sv
module calendar_time_counter
  import ctc_pkg::*;
#(
  parameter int TicksPerSecond = 32768,
  parameter int UipTicks       = 8,
  parameter int BaseYear       = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick32k,
  input  logic [2:0] oscSel,
  input  logic       setMode,
  input  logic       binMode,
  input  logic       mode24,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic [7:0] wrData,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] dowOut,
  output logic [7:0] domOut,
  output logic [7:0] monOut,
  output logic [7:0] yearOut,
  output logic       uip,
  output logic       updateEnded
);
  ctc_strobes_t strb;
  logic [NumFields-1:0][7:0] vis;

  ctc_control #(.TicksPerSecond(TicksPerSecond), .UipTicks(UipTicks)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .oscSel(oscSel),
    .setMode(setMode), .wrEn(wrEn), .strb(strb), .uip(uip),
    .updateEnded(updateEnded)
  );

  ctc_datapath #(.BaseYear(BaseYear)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .binMode(binMode), .mode24(mode24),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .vis(vis)
  );

  assign secOut  = vis[0];
  assign minOut  = vis[1];
  assign hourOut = vis[2];
  assign dowOut  = vis[3];
  assign domOut  = vis[4];
  assign monOut  = vis[5];
  assign yearOut = vis[6];
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] oscSel,
  input logic       setMode,
  input logic       wrEn,
  input logic       uip,
  input logic       updateEnded,
  input logic [7:0] secOut,
  input logic [7:0] minOut,
  input logic [7:0] hourOut,
  input logic [7:0] dowOut,
  input logic [7:0] domOut,
  input logic [7:0] monOut,
  input logic [7:0] yearOut
);
  // R7: an update window opens only under the running oscillator setting
  a_r7_osc_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uip) |-> $past(oscSel) == 3'b010);

  // R8: the end pulse coincides with uip being low
  a_r8_end_uip_low: assert property (@(posedge clk) disable iff (!rstN)
    updateEnded |-> !uip);

  // R8: a uip fall outside set mode is the end of an update
  a_r8_fall_ends: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(uip) && !$past(setMode)) |-> updateEnded);

  // R8: the end pulse lasts one cycle
  a_r8_end_single: assert property (@(posedge clk) disable iff (!rstN)
    updateEnded |=> !updateEnded);

  // R9: set mode keeps uip low
  a_r9_uip_low_in_set: assert property (@(posedge clk) disable iff (!rstN)
    $past(setMode) |-> !uip);

  // R9: in set mode only writes touch the visible bytes
  a_r9_vis_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ($past(setMode) && !$past(wrEn)) |->
      $stable({secOut, minOut, hourOut, dowOut, domOut, monOut, yearOut}));
endmodule

bind calendar_time_counter ctc_checker u_chk (.*);

// File: tb/tb_calendar_time_counter.sv
module tb_calendar_time_counter;
  localparam int ClkPeriod = 10;
  localparam int Tps = 16;
  localparam int Uip = 8;

  logic clk = 1'b0;
  logic rstN, tick32k, setMode, binMode, mode24, wrEn;
  logic [2:0] oscSel, wrSel;
  logic [7:0] wrData;
  logic [7:0] secOut, minOut, hourOut, dowOut, domOut, monOut, yearOut;
  logic uip, updateEnded;

  int errors = 0;
  int checks = 0;
  bit waitOk;

  always #(ClkPeriod / 2) clk = ~clk;

  calendar_time_counter #(.TicksPerSecond(Tps), .UipTicks(Uip), .BaseYear(2000)) dut (.*);

  logic [7:0] dOut [7];
  assign dOut[0] = secOut;  assign dOut[1] = minOut; assign dOut[2] = hourOut;
  assign dOut[3] = dowOut;  assign dOut[4] = domOut; assign dOut[5] = monOut;
  assign dOut[6] = yearOut;

  // ---------------- behavioural reference ----------------
  int mPresc, mWin;
  bit mBusy, mSetQ, mLoad, mUip, mEnd;
  int tv [7];
  int nt [7];
  logic [7:0] mv [7];
  logic [7:0] cb [7];

  function automatic logic [7:0] enc(int v, bit bin);
    if (bin) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dec(logic [7:0] b, bit bin);
    if (bin) return int'(b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(int mo, int yy);
    int y;
    y = 2000 + yy;
    if (mo == 2) return ((y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0))) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    bit secE, adv, done;
    if (!rstN) begin
      mPresc = 0; mWin = 0; mBusy = 0; mSetQ = 0; mLoad = 0; mUip = 0; mEnd = 0;
      tv[0] = 0; tv[1] = 0; tv[2] = 0; tv[3] = 1; tv[4] = 1; tv[5] = 1; tv[6] = 0;
      for (int i = 0; i < 7; i++) mv[i] = enc(tv[i], 1'b0);
    end else begin
      secE = tick32k && (mPresc == Tps - 1);
      adv  = secE && !mBusy && (oscSel == 3'b010);
      done = mBusy && tick32k && (mWin == Uip - 1);
      for (int i = 0; i < 7; i++) cb[i] = enc(tv[i], binMode);
      if (!mode24) cb[2] = enc(tv[2] % 12, binMode) | ((tv[2] >= 12) ? 8'h80 : 8'h00);
      for (int i = 0; i < 7; i++) nt[i] = tv[i];
      if (mLoad) begin
        for (int i = 0; i < 7; i++) nt[i] = dec(mv[i], binMode);
        nt[2] = dec(mv[2] & 8'h7f, binMode) + ((!mode24 && mv[2][7]) ? 12 : 0);
      end else if (adv) begin
        nt[0] = tv[0] + 1;
        if (nt[0] >= 60) begin
          nt[0] = 0; nt[1] = tv[1] + 1;
          if (nt[1] >= 60) begin
            nt[1] = 0; nt[2] = tv[2] + 1;
            if (nt[2] >= 24) begin
              nt[2] = 0;
              nt[3] = (tv[3] >= 7) ? 1 : tv[3] + 1;
              nt[4] = tv[4] + 1;
              if (nt[4] > mdays(tv[5], tv[6])) begin
                nt[4] = 1; nt[5] = tv[5] + 1;
                if (nt[5] > 12) begin
                  nt[5] = 1;
                  nt[6] = (tv[6] >= 99) ? 0 : tv[6] + 1;
                end
              end
            end
          end
        end
      end
      for (int i = 0; i < 7; i++) begin
        if (wrEn && int'(wrSel) == i) mv[i] = wrData;
        else if (done && !setMode)    mv[i] = cb[i];
      end
      for (int i = 0; i < 7; i++) tv[i] = nt[i];
      mEnd = done;
      if (setMode)   mUip = 0;
      else if (adv)  mUip = 1;
      else if (done) mUip = 0;
      mLoad = !setMode && (wrEn || mSetQ);
      mSetQ = setMode;
      if (tick32k) mPresc = secE ? 0 : mPresc + 1;
      if (adv) begin mBusy = 1; mWin = 0; end
      else if (mBusy && tick32k) begin
        if (done) mBusy = 0; else mWin = mWin + 1;
      end
    end
  end

  // per-cycle comparison against the reference (R2, R8)
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 7; i++) begin
        checks++;
        if (dOut[i] !== mv[i]) begin
          errors++;
          $display("FAIL R2 cycle compare field %0d: actual %02h expected %02h", i, dOut[i], mv[i]);
        end
      end
      checks++;
      if (uip !== mUip || updateEnded !== mEnd) begin
        errors++;
        $display("FAIL R8 cycle compare uip/end: actual %b%b expected %b%b", uip, updateEnded, mUip, mEnd);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic waitEnd();
    int n = 0;
    do begin @(negedge clk); n++; end while (!updateEnded && n < 100);
    waitOk = updateEnded;
  endtask

  task automatic writeByte(int sel, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'(sel); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTime(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] w,
                         logic [7:0] d, logic [7:0] mo, logic [7:0] y);
    logic [7:0] b [7];
    b[0] = s; b[1] = m; b[2] = h; b[3] = w; b[4] = d; b[5] = mo; b[6] = y;
    @(negedge clk);
    setMode = 1'b1;
    for (int i = 0; i < 7; i++) begin
      wrEn = 1'b1; wrSel = 3'(i); wrData = b[i];
      @(negedge clk);
    end
    wrEn = 1'b0;
    waitEnd();
    setMode = 1'b0;
    @(negedge clk);
  endtask

  task automatic expectAll(string req, logic [7:0] s, logic [7:0] m, logic [7:0] h,
                           logic [7:0] w, logic [7:0] d, logic [7:0] mo, logic [7:0] y);
    check({req, " seconds"}, secOut, s);
    check({req, " minutes"}, minOut, m);
    check({req, " hours"}, hourOut, h);
    check({req, " day of week"}, dowOut, w);
    check({req, " day of month"}, domOut, d);
    check({req, " month"}, monOut, mo);
    check({req, " year"}, yearOut, y);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt, ends;
    logic [7:0] prev;
    rstN = 1'b0; tick32k = 1'b1; oscSel = 3'b010; setMode = 1'b0;
    binMode = 1'b0; mode24 = 1'b1; wrEn = 1'b0; wrSel = '0; wrData = '0;
    repeat (3) @(negedge clk);
    expectAll("R1 reset", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    check("R1 reset uip", 8'(uip), 8'h00);
    check("R1 reset end", 8'(updateEnded), 8'h00);
    rstN = 1'b1;

    // R5 BCD with full rollover; R2 R3 carries
    setTime(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    waitEnd();
    expectAll("R5 R2 R3 BCD rollover", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);

    // R4 leap rules in binary (R5 binary)
    binMode = 1'b1;
    setTime(8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2, 8'd24);
    waitEnd();
    expectAll("R4 2024 Feb 28", 8'd0, 8'd0, 8'd0, 8'd4, 8'd29, 8'd2, 8'd24);
    setTime(8'd59, 8'd59, 8'd23, 8'd3, 8'd29, 8'd2, 8'd24);
    waitEnd();
    expectAll("R4 2024 Feb 29", 8'd0, 8'd0, 8'd0, 8'd4, 8'd1, 8'd3, 8'd24);
    setTime(8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2, 8'd1);
    waitEnd();
    expectAll("R4 2001 Feb 28", 8'd0, 8'd0, 8'd0, 8'd4, 8'd1, 8'd3, 8'd1);
    setTime(8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2, 8'd0);
    waitEnd();
    expectAll("R4 2000 Feb 28", 8'd0, 8'd0, 8'd0, 8'd4, 8'd29, 8'd2, 8'd0);
    setTime(8'd10, 8'd59, 8'd5, 8'd3, 8'd9, 8'd9, 8'd9);
    waitEnd();
    expectAll("R5 binary plain", 8'd11, 8'd59, 8'd5, 8'd3, 8'd9, 8'd9, 8'd9);

    // R3 30-day month
    binMode = 1'b0;
    setTime(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10);
    waitEnd();
    expectAll("R3 April 30", 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h05, 8'h10);

    // R6 12-hour display and load
    mode24 = 1'b0;
    setTime(8'h59, 8'h59, 8'h91, 8'h01, 8'h15, 8'h06, 8'h10);
    waitEnd();
    expectAll("R6 11 PM to midnight", 8'h00, 8'h00, 8'h00, 8'h02, 8'h16, 8'h06, 8'h10);
    setTime(8'h59, 8'h59, 8'h11, 8'h01, 8'h15, 8'h06, 8'h10);
    waitEnd();
    expectAll("R6 11 AM to noon", 8'h00, 8'h00, 8'h80, 8'h01, 8'h15, 8'h06, 8'h10);
    setTime(8'h59, 8'h30, 8'h85, 8'h01, 8'h15, 8'h06, 8'h10);
    waitEnd();
    expectAll("R6 PM kept", 8'h00, 8'h31, 8'h85, 8'h01, 8'h15, 8'h06, 8'h10);
    mode24 = 1'b1;

    // R8 update window timing
    setTime(8'h10, 8'h20, 8'h08, 8'h02, 8'h05, 8'h05, 8'h05);
    waitEnd();
    check("R8 first second", secOut, 8'h11);
    while (!uip) @(negedge clk);
    cnt = 0;
    while (uip) begin
      check("R8 bytes held while uip", secOut, 8'h11);
      cnt++;
      @(negedge clk);
    end
    check("R8 uip width", 8'(cnt), 8'(Uip));
    check("R8 end with fall", 8'(updateEnded), 8'h01);
    check("R8 copy at fall", secOut, 8'h12);
    @(negedge clk);
    check("R8 end one cycle", 8'(updateEnded), 8'h00);

    // R10 write outside set mode reloads the counter
    waitEnd();
    writeByte(0, 8'h30);
    check("R10 byte written", secOut, 8'h30);
    waitEnd();
    check("R10 reload then advance", secOut, 8'h31);
    check("R10 other field kept", minOut, 8'h20);

    // R7 oscillator gate
    waitEnd();
    prev = secOut;
    oscSel = 3'b000;
    cnt = 0; ends = 0;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      if (uip) cnt++;
      if (updateEnded) ends++;
    end
    check("R7 no uip when stopped", 8'(cnt), 8'h00);
    check("R7 no end when stopped", 8'(ends), 8'h00);
    check("R7 time held", secOut, prev);
    oscSel = 3'b010;
    waitEnd();
    check("R7 resumes", secOut, 8'(prev + 8'h01));

    // R9 set mode freeze and reload
    waitEnd();
    prev = secOut;
    @(negedge clk);
    setMode = 1'b1;
    cnt = 0;
    for (int k = 0; k < 2; k++) begin
      waitEnd();
      check("R9 end still pulses", 8'(waitOk), 8'h01);
    end
    check("R9 bytes frozen", secOut, prev);
    setMode = 1'b0;
    waitEnd();
    check("R9 reload discards hidden run", secOut, 8'(prev + 8'h01));

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule